// File: doc/BRIEF.md
# Zone Access History Map

This block keeps a compact record of which cache lines have been touched inside fixed-size regions of memory. Each region, called a zone, spans 256 consecutive lines of 64 bytes. The record is a set-associative table. Each entry stores a zone tag, one touched/untouched bit for every line of the zone, a count of accesses to the zone and a count of the accesses that were reuses. A replacement or insertion policy placed next to a last-level cache feeds the block the line address of each cache lookup. The block then tells that policy whether this line was touched before and how reuse-heavy the surrounding zone has been.

The block takes line-granular addresses together with a valid strobe. One cycle later it returns a result. The result marks the access either as a first touch or as a data reuse, and it also carries the zone's updated access and reuse counts. An address that matches no entry allocates one in its set. The victim is the lowest-numbered invalid way if one exists, and the least recently used way otherwise. The response path is a two-state machine. In `S_QUIET` no result is presented. In `S_REPORT` a result is valid. The transition into `S_REPORT`, and the stay in it, happen on every cycle with a strobe. The transition into `S_QUIET`, and the stay in it, happen on every cycle without one. Each line bit also has two named states. `LINE_INIT` means untouched. `LINE_ACCESS` means touched. The only transition is `LINE_INIT` to `LINE_ACCESS` on a line's first touch, and an entry allocation returns every line of that entry to `LINE_INIT`.

Top module: `zone_access_map`

## Requirements
- R1: The line address splits so that bits [7:0] select the line within its zone, bits [11:8] select one of 16 sets, and the bits above them form the zone tag. Two addresses that differ only in the set bits belong to different zones.
- R2: An access to a line whose bit is untouched, or to a zone not present in the table, reports `rsp_reuse` = 0. It also marks the line as touched.
- R3: An access to a line that is already touched in a present zone reports `rsp_reuse` = 1.
- R4: Each access to a present zone raises its access count by one. The reported count is the value after the update.
- R5: Each reuse raises the zone's reuse count by one. The reported reuse count is the value after the update, and it is always below the reported access count.
- R6: The counters are 6 bits wide. When an access would take the access count past 63, both counters take their incremented values shifted right by one. The access count therefore becomes 32, and a reuse count of 62 followed by a reuse becomes 31.
- R7: On a zone miss, the new entry has only the accessed line touched, an access count of 1 and a reuse count of 0. The access is reported as a first touch.
- R8: When all 12 ways of a set are valid, a miss replaces the way whose zone was looked up least recently. The other zones of the set keep their history.
- R9: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high.
- R10: A synchronous reset invalidates every entry and clears `rsp_valid`. After reset, every line reports a first touch with an access count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup strobe |
| req_line_addr | input | 26 | Line address (byte offset already removed) |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_reuse | output | 1 | 1 = data reuse, 0 = first touch |
| rsp_acc_cnt | output | 6 | Zone access count after this access |
| rsp_reuse_cnt | output | 6 | Zone reuse count after this access |

## Verification
A corrupted line bit shows up on the very next lookup of that line, as a reuse flag with the wrong value. A bad tag or a bad replacement choice appears when a zone that should survive suddenly reports an access count of 1. It also appears when a zone that should have left the table keeps counting. Either way it shows in the first lookup of that zone after the faulty allocation. Counter faults show in every result of the zone they hit, and the largest error appears at the 64-access halving boundary. The bench therefore walks a set through full occupancy and eviction, and it drives one line across the saturation point.

// File: rtl/zmap_pkg.sv
package zmap_pkg;

    typedef enum logic {
        LINE_INIT   = 1'b0,
        LINE_ACCESS = 1'b1
    } line_state_t;

    typedef enum logic {
        S_QUIET  = 1'b0,
        S_REPORT = 1'b1
    } rsp_state_t;

endpackage

// File: rtl/zmap_match.sv
module zmap_match #(
    parameter int WAYS  = 12,
    parameter int TAG_W = 14,
    parameter int WAY_W = $clog2(WAYS),
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS*AGE_W-1:0] way_ages,
    input  logic [TAG_W-1:0]      look_tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      victim_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tags[g*TAG_W +: TAG_W] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_valid[w]) begin
                found      = 1'b1;
                victim_way = WAY_W'(w);
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_ages[w*AGE_W +: AGE_W] == AGE_W'(WAYS - 1)) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/zmap_lru.sv
module zmap_lru #(
    parameter int WAYS  = 12,
    parameter int WAY_W = $clog2(WAYS),
    parameter int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS*AGE_W-1:0] age_in,
    input  logic [WAY_W-1:0]      touch_way,
    output logic [WAYS*AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] touched_age;

    always_comb begin
        touched_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way) touched_age = age_in[w*AGE_W +: AGE_W];
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_age
        logic [AGE_W-1:0] a;
        assign a = age_in[g*AGE_W +: AGE_W];
        assign age_out[g*AGE_W +: AGE_W] =
            (WAY_W'(g) == touch_way) ? '0 :
            (a < touched_age)        ? a + 1'b1 : a;
    end
endmodule

// File: rtl/zmap_cnt.sv
module zmap_cnt #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] acc_in,
    input  logic [CNT_W-1:0] rc_in,
    input  logic             is_new,
    input  logic             is_reuse,
    output logic [CNT_W-1:0] acc_out,
    output logic [CNT_W-1:0] rc_out
);
    logic [CNT_W:0] acc_sum;
    logic [CNT_W:0] rc_sum;

    always_comb begin
        acc_sum = {1'b0, acc_in} + 1'b1;
        rc_sum  = {1'b0, rc_in} + {{CNT_W{1'b0}}, is_reuse};
        if (is_new) begin
            acc_out = CNT_W'(1);
            rc_out  = '0;
        end else if (acc_sum[CNT_W]) begin
            acc_out = acc_sum[CNT_W:1];
            rc_out  = rc_sum[CNT_W:1];
        end else begin
            acc_out = acc_sum[CNT_W-1:0];
            rc_out  = rc_sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/zone_access_map.sv
module zone_access_map
    import zmap_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int OFF_W  = 8,
    parameter int IDX_W  = 4,
    parameter int WAYS   = 12,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_line_addr,
    output logic              rsp_valid,
    output logic              rsp_reuse,
    output logic [CNT_W-1:0]  rsp_acc_cnt,
    output logic [CNT_W-1:0]  rsp_reuse_cnt
);
    localparam int SETS  = 1 << IDX_W;
    localparam int LINES = 1 << OFF_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = $clog2(WAYS);

    logic [WAYS-1:0]  valid_mem [SETS];
    logic [AGE_W-1:0] age_mem   [SETS][WAYS];
    logic [TAG_W-1:0] tag_mem   [SETS][WAYS];
    logic [LINES-1:0] line_mem  [SETS][WAYS];
    logic [CNT_W-1:0] acc_mem   [SETS][WAYS];
    logic [CNT_W-1:0] rc_mem    [SETS][WAYS];

    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    assign off     = req_line_addr[OFF_W-1:0];
    assign set_idx = req_line_addr[IDX_W+OFF_W-1:OFF_W];
    assign tag     = req_line_addr[ADDR_W-1:IDX_W+OFF_W];

    logic [WAYS*TAG_W-1:0] sel_tags;
    logic [WAYS*AGE_W-1:0] sel_ages;
    logic [WAYS*AGE_W-1:0] new_ages;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            sel_tags[w*TAG_W +: TAG_W] = tag_mem[set_idx][w];
            sel_ages[w*AGE_W +: AGE_W] = age_mem[set_idx][w];
        end
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;
    logic [WAY_W-1:0] way;

    zmap_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .way_valid  (valid_mem[set_idx]),
        .way_tags   (sel_tags),
        .way_ages   (sel_ages),
        .look_tag   (tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    assign way = hit ? hit_way : victim_way;

    zmap_lru #(.WAYS(WAYS)) i_lru (
        .age_in    (sel_ages),
        .touch_way (way),
        .age_out   (new_ages)
    );

    logic [LINES-1:0] cur_bits;
    logic [LINES-1:0] touch_bit;
    line_state_t      prev_state;
    logic             is_reuse;

    always_comb begin
        cur_bits  = hit ? line_mem[set_idx][way] : '0;
        touch_bit = '0;
        touch_bit[off] = 1'b1;
        prev_state = line_state_t'(cur_bits[off]);
        is_reuse   = hit && (prev_state == LINE_ACCESS);
    end

    logic [CNT_W-1:0] acc_next;
    logic [CNT_W-1:0] rc_next;

    zmap_cnt #(.CNT_W(CNT_W)) i_cnt (
        .acc_in   (acc_mem[set_idx][way]),
        .rc_in    (rc_mem[set_idx][way]),
        .is_new   (!hit),
        .is_reuse (is_reuse),
        .acc_out  (acc_next),
        .rc_out   (rc_next)
    );

    // Entry payload: no reset, guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (req_valid) begin
            tag_mem[set_idx][way]  <= tag;
            line_mem[set_idx][way] <= cur_bits | touch_bit;
            acc_mem[set_idx][way]  <= acc_next;
            rc_mem[set_idx][way]   <= rc_next;
        end
    end

    // Valid bits and recency ages.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_mem[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_mem[s][w] <= AGE_W'(w);
            end
        end else if (req_valid) begin
            valid_mem[set_idx][way] <= 1'b1;
            for (int w = 0; w < WAYS; w++) age_mem[set_idx][w] <= new_ages[w*AGE_W +: AGE_W];
        end
    end

    // Response state register.
    rsp_state_t state;
    always_ff @(posedge clk) begin
        if (rst) state <= S_QUIET;
        else     state <= req_valid ? S_REPORT : S_QUIET;
    end

    // Result payload register.
    logic             res_reuse;
    logic [CNT_W-1:0] res_acc;
    logic [CNT_W-1:0] res_rc;
    always_ff @(posedge clk) begin
        if (rst) begin
            res_reuse <= 1'b0;
            res_acc   <= '0;
            res_rc    <= '0;
        end else if (req_valid) begin
            res_reuse <= is_reuse;
            res_acc   <= acc_next;
            res_rc    <= rc_next;
        end
    end

    // Outputs by state.
    always_comb begin
        unique case (state)
            S_QUIET: begin
                rsp_valid     = 1'b0;
                rsp_reuse     = 1'b0;
                rsp_acc_cnt   = '0;
                rsp_reuse_cnt = '0;
            end
            S_REPORT: begin
                rsp_valid     = 1'b1;
                rsp_reuse     = res_reuse;
                rsp_acc_cnt   = res_acc;
                rsp_reuse_cnt = res_rc;
            end
            default: begin
                rsp_valid     = 1'b0;
                rsp_reuse     = 1'b0;
                rsp_acc_cnt   = '0;
                rsp_reuse_cnt = '0;
            end
        endcase
    end
endmodule

// File: rtl/zmap_chk.sv
module zmap_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_reuse,
    input logic [CNT_W-1:0] rsp_acc_cnt,
    input logic [CNT_W-1:0] rsp_reuse_cnt
);
    // R9
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R5
    reuse_below_access_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_reuse_cnt < rsp_acc_cnt));

    // R7
    fresh_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_acc_cnt == CNT_W'(1)) |-> (!rsp_reuse && rsp_reuse_cnt == '0));

    // R3
    reuse_counted_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_reuse) |-> (rsp_reuse_cnt != '0));

    // R4
    access_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_acc_cnt != '0));
endmodule

bind zone_access_map zmap_chk #(.CNT_W(CNT_W)) i_zmap_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_reuse     (rsp_reuse),
    .rsp_acc_cnt   (rsp_acc_cnt),
    .rsp_reuse_cnt (rsp_reuse_cnt)
);

// File: tb/test_zone_access_map.sv
module test_zone_access_map;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [25:0] req_line_addr = '0;
    logic        rsp_valid;
    logic        rsp_reuse;
    logic [5:0]  rsp_acc_cnt;
    logic [5:0]  rsp_reuse_cnt;

    zone_access_map i_zone_access_map (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_line_addr(req_line_addr),
        .rsp_valid(rsp_valid), .rsp_reuse(rsp_reuse),
        .rsp_acc_cnt(rsp_acc_cnt), .rsp_reuse_cnt(rsp_reuse_cnt)
    );

    always #5ns clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference table: timestamps for recency.
    bit       m_valid [16][12];
    int       m_tag   [16][12];
    bit [255:0] m_bits [16][12];
    int       m_acc   [16][12];
    int       m_rc    [16][12];
    longint   m_stamp [16][12];
    longint   now = 0;

    function automatic logic [25:0] mk(int t, int s, int o);
        return {t[13:0], s[3:0], o[7:0]};
    endfunction

    task automatic model_access(input logic [25:0] a, output int e_reuse, output int e_acc, output int e_rc);
        int s = int'(a[11:8]);
        int o = int'(a[7:0]);
        int t = int'(a[25:12]);
        int w = -1;
        now++;
        for (int i = 0; i < 12; i++) if (m_valid[s][i] && m_tag[s][i] == t) w = i;
        if (w >= 0) begin
            e_reuse = m_bits[s][w][o] ? 1 : 0;
            m_bits[s][w][o] = 1'b1;
            m_acc[s][w] += 1;
            m_rc[s][w]  += e_reuse;
            if (m_acc[s][w] > 63) begin
                m_acc[s][w] = m_acc[s][w] / 2;
                m_rc[s][w]  = m_rc[s][w] / 2;
            end
        end else begin
            for (int i = 11; i >= 0; i--) if (!m_valid[s][i]) w = i;
            if (w < 0) begin
                w = 0;
                for (int i = 1; i < 12; i++) if (m_stamp[s][i] < m_stamp[s][w]) w = i;
            end
            m_valid[s][w] = 1'b1;
            m_tag[s][w]   = t;
            m_bits[s][w]  = '0;
            m_bits[s][w][o] = 1'b1;
            m_acc[s][w]   = 1;
            m_rc[s][w]    = 0;
            e_reuse = 0;
        end
        m_stamp[s][w] = now;
        e_acc = m_acc[s][w];
        e_rc  = m_rc[s][w];
    endtask

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // Drive at a negative edge, check the result at the next one.
    task automatic step(input bit v, input logic [25:0] a);
        int er, ea, ec;
        req_valid = v;
        req_line_addr = a;
        if (v) model_access(a, er, ea, ec);
        @(negedge clk);
        req_valid = 1'b0;
        if (v) begin
            chk("R9 valid", int'(rsp_valid), 1);
            chk(er != 0 ? "R3 reuse" : "R2 reuse", int'(rsp_reuse), er);
            chk("R4 acc", int'(rsp_acc_cnt), ea);
            chk("R5 rc", int'(rsp_reuse_cnt), ec);
        end else begin
            chk("R9 idle", int'(rsp_valid), 0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        for (int s = 0; s < 16; s++) for (int w = 0; w < 12; w++) m_valid[s][w] = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2ms;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        @(negedge clk);
        do_reset();
        // R10: nothing reported out of reset
        chk("R10 rsp_valid after reset", int'(rsp_valid), 0);

        // R2 then R3 on the same line
        step(1, mk(7, 3, 9));
        chk("R2 first touch", int'(rsp_reuse), 0);
        step(1, mk(7, 3, 9));
        chk("R3 reuse", int'(rsp_reuse), 1);
        // neighbour line in same zone: first touch, zone count grows
        step(1, mk(7, 3, 10));
        chk("R4 zone acc", int'(rsp_acc_cnt), 3);
        // R1: same tag and offset, other set -> separate zone
        step(1, mk(7, 4, 9));
        chk("R1 other set is other zone", int'(rsp_acc_cnt), 1);
        step(0, '0);

        // R6: drive one line to the saturation point
        for (int i = 0; i < 60; i++) step(1, mk(7, 3, 9));
        chk("R6 before halving", int'(rsp_acc_cnt), 63);
        step(1, mk(7, 3, 9));
        chk("R6 acc halved", int'(rsp_acc_cnt), 32);
        chk("R6 rc halved", int'(rsp_reuse_cnt), 31);

        // R7 / R8: fill set 5, refresh the oldest, then overflow
        for (int t = 100; t < 112; t++) step(1, mk(t, 5, 1));
        step(1, mk(100, 5, 2));
        step(1, mk(112, 5, 3));
        chk("R7 new entry acc", int'(rsp_acc_cnt), 1);
        chk("R7 new entry rc", int'(rsp_reuse_cnt), 0);
        step(1, mk(100, 5, 1));
        chk("R8 refreshed zone kept", int'(rsp_acc_cnt), 3);
        chk("R8 refreshed zone reuse", int'(rsp_reuse), 1);
        step(1, mk(101, 5, 1));
        chk("R8 LRU zone evicted", int'(rsp_acc_cnt), 1);

        // Constrained random traffic over two sets
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom % 8) != 0;
            step(v, mk($urandom % 18, 6 + ($urandom % 2), $urandom % 12));
        end

        // R10: reset in mid-run forgets all history
        do_reset();
        step(1, mk(7, 3, 9));
        chk("R10 history cleared", int'(rsp_acc_cnt), 1);
        chk("R10 first touch", int'(rsp_reuse), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule